// File: doc/BRIEF.md
# Reset Source Discrimination Sequencer

This block sequences the core out of reset and works out which of four causes started the reset: a cold power-on, a low level forced onto the shared reset pin from outside, a watchdog timeout, or a clock-monitor fault. Whenever the block starts a reset sequence, it pulls the open-drain reset pin low for `DRIVE_CYC` E-clock cycles and then lets it go. After a further `SAMPLE_DLY` cycles it reads the pin. A pin that is still low means an outside device is holding reset, so the reset is classed as external. A pin that has come back high means the block's own recorded internal cause is the reason for the reset.

The result goes to the core as a two-bit vector-select code. The code is loaded on the same edge that releases the core from reset. Power-on enters reset asynchronously, with no clock needed. Every way out of reset is timed by the clock.

The controller has four states. S_DRIVE drives the pin low. S_SETTLE waits with the pin released. S_EXTHOLD holds the core in reset while the pin is low from outside. S_RUN lets the core run. The transitions are:
- power-on goes to S_DRIVE;
- S_DRIVE goes to S_SETTLE when the drive count ends;
- S_SETTLE goes to S_RUN if the pin reads high at the sample, and to S_EXTHOLD if it reads low;
- S_EXTHOLD goes to S_DRIVE when the pin rises;
- S_RUN goes to S_EXTHOLD when the pin falls;
- S_RUN goes to S_DRIVE on a watchdog or clock-monitor fault pulse.

Top module: `rst_src_seq`

## Requirements
- R1: While `por_n` is low, `core_rst` and `pin_oe` are 1 and `vec_sel` is 2'b00, with no clock edge needed. Once `por_n` rises, the reset sequence runs as described below.
- R2: Each reset sequence drives `pin_oe` high for exactly `DRIVE_CYC` (16) consecutive cycles. `pin_oe` is never high while `core_rst` is 0.
- R3: `SAMPLE_DLY` (8) cycles after `pin_oe` falls, the block samples `pin_in`. If the sample is 1, `core_rst` falls on that same edge, 24 edges after the sequence starts. Any low level on the pin that ends before the sample has no effect.
- R4: If `pin_in` is 0 at the sample, the reset is external. `core_rst` stays 1 until `pin_in` returns to 1, and the full 16+8 sequence then runs again. The release code is 2'b00 whatever internal causes were recorded.
- R5: A watchdog pulse, with no clock-monitor fault and no external reset in the same sequence, gives the release code 2'b10.
- R6: A clock-monitor pulse gives the release code 2'b01. If a watchdog pulse is also recorded in the same sequence, the clock monitor still wins.
- R7: A power-on reset with no internal cause gives the release code 2'b00.
- R8: If `pin_in` goes low while the core is running, `core_rst` is 1 on the next edge and `pin_oe` stays 0 for as long as the pin is held low.
- R9: `vec_sel` changes only on the edge where `core_rst` falls, or through an asynchronous power-on. It is never 2'b11.
- R10: Recorded causes are cleared when the core is released. A later sequence reports only its own causes.
- R11: A watchdog or clock-monitor pulse while the core is running (pin high) sets `pin_oe` and `core_rst` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | E-clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wdog_fault | input | 1 | Watchdog timeout pulse |
| clkmon_fault | input | 1 | Clock-monitor fault pulse |
| pin_in | input | 1 | Sampled level of the reset pin |
| pin_oe | output | 1 | Drives the reset pin low when 1 |
| core_rst | output | 1 | Holds the core in reset when 1 |
| vec_sel | output | 2 | Vector select: 00 normal, 01 clock monitor, 10 watchdog |

## Verification
Some properties are checked by assertions on every cycle:
- the pin is driven only while the core is held in reset;
- the next-edge response to a fault or to an outside pin pull while the core is running;
- the pin level read at the moment of release;
- the clearing of recorded causes;
- the stability and legality of the vector code.

Other properties only the bench's scenarios can show. These are the exact 16-cycle drive and 24-cycle release timing, and the priority among causes at release. They also include the boundary where an outside pull ends just before or just after the sample, and the restart that follows an external hold. Random fault times and pin pulls are mixed with directed cases for these.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    typedef enum logic [1:0] {
        S_DRIVE   = 2'd0,
        S_SETTLE  = 2'd1,
        S_EXTHOLD = 2'd2,
        S_RUN     = 2'd3
    } seq_state_t;

    localparam logic [1:0] VEC_NORMAL = 2'b00;
    localparam logic [1:0] VEC_CLKMON = 2'b01;
    localparam logic [1:0] VEC_WDOG   = 2'b10;
endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int DRIVE_CYC  = 16,
    parameter int SAMPLE_DLY = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic restart,
    input  logic active,
    output logic drive_done,
    output logic settle_done
);
    localparam int CMAX = (DRIVE_CYC > SAMPLE_DLY) ? DRIVE_CYC : SAMPLE_DLY;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] DRV_LAST = CW'(DRIVE_CYC - 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SAMPLE_DLY - 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(CMAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (active && cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign drive_done  = (cnt_q == DRV_LAST);
    assign settle_done = (cnt_q == SET_LAST);
endmodule

// File: rtl/rst_cause_latch.sv
module rst_cause_latch
    import rst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       wdog_set,
    input  logic       clkmon_set,
    input  logic       ext_set,
    input  logic       clr,
    output logic [1:0] cause_code
);
    logic wd_q, cm_q, ext_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wd_q  <= 1'b0;
            cm_q  <= 1'b0;
            ext_q <= 1'b0;
        end else if (clr) begin
            wd_q  <= 1'b0;
            cm_q  <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            wd_q  <= wd_q  | wdog_set;
            cm_q  <= cm_q  | clkmon_set;
            ext_q <= ext_q | ext_set;
        end
    end

    // External beats clock monitor, which beats watchdog.
    always_comb begin
        if (ext_q)     cause_code = VEC_NORMAL;
        else if (cm_q) cause_code = VEC_CLKMON;
        else if (wd_q) cause_code = VEC_WDOG;
        else           cause_code = VEC_NORMAL;
    end

    // R10: a release clears every recorded cause
    p_clr_causes_r10: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (cause_code == VEC_NORMAL));
endmodule

// File: rtl/rst_src_seq.sv
module rst_src_seq
    import rst_seq_pkg::*;
#(
    parameter int DRIVE_CYC  = 16,
    parameter int SAMPLE_DLY = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wdog_fault,
    input  logic       clkmon_fault,
    input  logic       pin_in,
    output logic       pin_oe,
    output logic       core_rst,
    output logic [1:0] vec_sel
);
    seq_state_t state_q, state_d;
    logic       restart, release_core, ext_set;
    logic       drive_done, settle_done;
    logic [1:0] cause_code;

    rst_seq_timer #(.DRIVE_CYC(DRIVE_CYC), .SAMPLE_DLY(SAMPLE_DLY)) u_timer (
        .clk         (clk),
        .por_n       (por_n),
        .restart     (restart),
        .active      ((state_q == S_DRIVE) || (state_q == S_SETTLE)),
        .drive_done  (drive_done),
        .settle_done (settle_done)
    );

    rst_cause_latch u_cause (
        .clk        (clk),
        .por_n      (por_n),
        .wdog_set   (wdog_fault),
        .clkmon_set (clkmon_fault),
        .ext_set    (ext_set),
        .clr        (release_core),
        .cause_code (cause_code)
    );

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= S_DRIVE;
        else        state_q <= state_d;
    end

    // Next state and transition strobes
    always_comb begin
        state_d      = state_q;
        restart      = 1'b0;
        release_core = 1'b0;
        ext_set      = 1'b0;
        unique case (state_q)
            S_DRIVE: begin
                if (drive_done) begin
                    state_d = S_SETTLE;
                    restart = 1'b1;
                end
            end
            S_SETTLE: begin
                if (settle_done) begin
                    restart = 1'b1;
                    if (!pin_in) begin
                        state_d = S_EXTHOLD;
                        ext_set = 1'b1;
                    end else begin
                        state_d      = S_RUN;
                        release_core = 1'b1;
                    end
                end
            end
            S_EXTHOLD: begin
                if (pin_in) begin
                    state_d = S_DRIVE;
                    restart = 1'b1;
                end
            end
            S_RUN: begin
                if (!pin_in) begin
                    state_d = S_EXTHOLD;
                    ext_set = 1'b1;
                end else if (wdog_fault || clkmon_fault) begin
                    state_d = S_DRIVE;
                    restart = 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        pin_oe   = (state_q == S_DRIVE);
        core_rst = (state_q != S_RUN);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)            vec_sel <= VEC_NORMAL;
        else if (release_core) vec_sel <= cause_code;
    end

    p_oe_in_reset_r2: assert property (@(posedge clk) disable iff (!por_n)
        pin_oe |-> core_rst);

    p_release_pin_high_r3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(core_rst) |-> $past(pin_in));

    p_ext_in_run_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!core_rst && !pin_in) |=> (core_rst && !pin_oe));

    p_fault_in_run_r11: assert property (@(posedge clk) disable iff (!por_n)
        (!core_rst && pin_in && (wdog_fault || clkmon_fault)) |=> pin_oe);

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        !$fell(core_rst) |-> $stable(vec_sel));

    p_vec_legal_r9: assert property (@(posedge clk) disable iff (!por_n)
        vec_sel != 2'b11);
endmodule

// File: tb/rst_src_seq_test.sv
module rst_src_seq_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wdog_fault = 1'b0;
    logic       clkmon_fault = 1'b0;
    logic       ext_low = 1'b0;
    logic       pin_in;
    logic       pin_oe, core_rst;
    logic [1:0] vec_sel;
    int         checks = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    // Open-drain pin: low if either side pulls it
    assign pin_in = !(pin_oe || ext_low);

    rst_src_seq uut (
        .clk(clk), .por_n(por_n), .wdog_fault(wdog_fault), .clkmon_fault(clkmon_fault),
        .pin_in(pin_in), .pin_oe(pin_oe), .core_rst(core_rst), .vec_sel(vec_sel)
    );

    function automatic logic [1:0] exp_vec(input logic ext, input logic cm, input logic wd);
        if (ext)     return 2'b00;
        else if (cm) return 2'b01;
        else if (wd) return 2'b10;
        return 2'b00;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge where a sequence is in its first drive cycle.
    task automatic run_seq(input int wd_at, input int cm_at, input int ext_from,
                           input int ext_len, input logic trig_wd, input logic trig_cm,
                           input string tag);
        int oe_cyc = 0;
        int total = 0;
        logic vec_ok = 1'b1;
        logic [1:0] vec0 = vec_sel;
        logic ext = (ext_from >= 0) && (ext_from <= 23) && (ext_from + ext_len > 23);
        logic wd = trig_wd || (wd_at >= 0 && wd_at <= 22);
        logic cm = trig_cm || (cm_at >= 0 && cm_at <= 22);
        int exp_total = ext ? (ext_from + ext_len + 25) : 24;
        int exp_oe = ext ? 32 : 16;
        for (int i = 0; i < 200; i++) begin
            if (!core_rst) break;
            if (pin_oe) oe_cyc++;
            if (vec_sel != vec0) vec_ok = 1'b0;
            wdog_fault   = (i == wd_at);
            clkmon_fault = (i == cm_at);
            ext_low      = (i >= ext_from) && (ext_from >= 0) && (i < ext_from + ext_len);
            total++;
            @(negedge clk);
        end
        wdog_fault = 1'b0;
        clkmon_fault = 1'b0;
        ext_low = 1'b0;
        chk(oe_cyc == exp_oe, {"R2 drive length ", tag}, oe_cyc, exp_oe);
        chk(total == exp_total, {ext ? "R4 restart " : "R3 release time ", tag}, total, exp_total);
        chk(vec_ok, {"R9 vec stable in reset ", tag}, 0, 1);
        chk(vec_sel == exp_vec(ext, cm, wd), {"R5 R6 R7 vector ", tag}, vec_sel, exp_vec(ext, cm, wd));
    endtask

    // Called at a negedge with the core running.
    task automatic trigger(input logic wd, input logic cm);
        chk(!core_rst, "R11 core running before fault", core_rst, 0);
        wdog_fault = wd;
        clkmon_fault = cm;
        @(negedge clk);
        chk(pin_oe && core_rst, "R11 fault starts sequence", pin_oe, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(core_rst && pin_oe && vec_sel == 2'b00, "R1 power-on state", {core_rst, pin_oe, vec_sel}, 4'b1100);
        por_n = 1'b1;
        run_seq(-1, -1, -1, 0, 1'b0, 1'b0, "R7 cold start");

        trigger(1'b1, 1'b0);
        run_seq(-1, -1, -1, 0, 1'b1, 1'b0, "R5 watchdog");
        trigger(1'b0, 1'b1);
        run_seq(-1, -1, -1, 0, 1'b0, 1'b1, "R6 clock monitor");
        trigger(1'b1, 1'b0);
        run_seq(-1, -1, -1, 0, 1'b1, 1'b0, "R10 cleared after clock monitor");
        trigger(1'b1, 1'b0);
        run_seq(-1, 5, -1, 0, 1'b1, 1'b0, "R6 monitor beats watchdog");
        trigger(1'b1, 1'b0);
        run_seq(-1, -1, 2, 8, 1'b1, 1'b0, "R3 early pull ignored");
        trigger(1'b1, 1'b0);
        run_seq(-1, -1, 23, 1, 1'b1, 1'b0, "R4 pull at sample edge");
        trigger(1'b0, 1'b1);
        run_seq(-1, -1, 0, 32, 1'b0, 1'b1, "R4 32-cycle hold");

        // R8 outside pull while running
        ext_low = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(core_rst && !pin_oe, "R8 held by outside pull", {core_rst, pin_oe}, 2'b10);
        end
        ext_low = 1'b0;
        @(negedge clk);
        run_seq(-1, -1, -1, 0, 1'b0, 1'b0, "R8 after outside pull");

        // R1 asynchronous power-on while running
        trigger(1'b0, 1'b1);
        run_seq(-1, -1, -1, 0, 1'b0, 1'b1, "R6 before power-on");
        #1 por_n = 1'b0;
        #0.5;
        chk(core_rst && pin_oe && vec_sel == 2'b00, "R1 async entry", {core_rst, pin_oe, vec_sel}, 4'b1100);
        @(negedge clk);
        por_n = 1'b1;
        run_seq(-1, -1, -1, 0, 1'b0, 1'b0, "R7 warm power-on");

        for (int n = 0; n < 40; n++) begin
            logic tw = $urandom_range(1, 0) == 1;
            int wd_at = ($urandom_range(2, 0) == 0) ? int'($urandom_range(22, 0)) : -1;
            int cm_at = ($urandom_range(2, 0) == 0) ? int'($urandom_range(22, 0)) : -1;
            int ef = ($urandom_range(2, 0) == 0) ? int'($urandom_range(23, 0)) : -1;
            int el = int'($urandom_range(20, 1));
            trigger(tw, !tw);
            run_seq(wd_at, cm_at, ef, el, tw, !tw, "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule